// File: doc/BRIEF.md
# Packed Lane Add/Subtract Unit

This block performs packed arithmetic on two 32-bit operands as independent lanes: two 16-bit lanes, or four 8-bit lanes. It covers plain modulo lane addition and subtraction, the two cross-paired halfword variants, an unsigned sum of byte absolute differences (with an optional accumulator input), and a byte-wise select steered by greater-or-equal flags. The lane carry chain is broken at every lane boundary, so no carry or borrow passes from one lane into its neighbour.

The data result is combinational in the operands and the opcode. The four greater-or-equal flags are held in a register. Lane add and subtract operations update this register at the clock edge when `op_valid` is high. The select operation reads the register, and a later select can then pick bytes according to the outcome of an earlier comparison-style subtract. The flag register clears on an asynchronous active-low reset.

Top module: `simd_addsub_unit`

## Requirements
- R1: While `rst_n` is low, and after its release until the first flag-writing operation, `ge_flags` is 0.
- R2: Opcodes 0 (halfword add) and 1 (halfword subtract) give each 16-bit lane result modulo 2^16 with no carry between the lanes. At the next clock edge with `op_valid` high, flags [3:2] both take the upper lane's carry-out (add) or no-borrow (subtract), and flags [1:0] both take the lower lane's.
- R3: Opcodes 2 (byte add) and 3 (byte subtract) treat bits [31:24], [23:16], [15:8] and [7:0] as four independent lanes. Flag i takes byte lane i's carry-out (add) or no-borrow, i.e. opa byte >= opb byte (subtract).
- R4: Opcode 4 (cross add-subtract) gives opa[31:16]+opb[15:0] in the upper lane and opa[15:0]−opb[31:16] in the lower lane. Flags follow R2, using carry for the upper lane and no-borrow for the lower lane.
- R5: Opcode 5 (cross subtract-add) gives opa[31:16]−opb[15:0] in the upper lane and opa[15:0]+opb[31:16] in the lower lane. Flags follow R2, using no-borrow for the upper lane and carry for the lower lane.
- R6: Opcode 6 returns the sum of the four unsigned byte absolute differences |opa byte − opb byte|.
- R7: Opcode 7 returns `acc` plus the R6 sum, modulo 2^32.
- R8: Opcode 8 returns, for each byte i, opa byte i when `ge_flags[i]` is 1 and opb byte i otherwise. It uses the flags as registered before the current edge.
- R9: Opcodes 6, 7, 8, opcodes 9–15, and any cycle with `op_valid` low leave `ge_flags` unchanged.
- R10: Opcodes 9–15 return a result of 0. The result follows the opcode and operands whatever the level of `op_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Issue strobe; allows the flag register to update |
| op | input | 4 | Operation code (see R2–R10) |
| opa | input | 32 | First packed operand |
| opb | input | 32 | Second packed operand |
| acc | input | 32 | Accumulator for opcode 7 |
| result | output | 32 | Packed result |
| ge_flags | output | 4 | Registered greater-or-equal flags, bit i per byte lane |

## Verification
The flag write from a lane add or subtract and the flag read by the select can fall on neighbouring cycles. A select issued right after an arithmetic operation must use the flags written at that edge, and must not use the flags from before it. The bench issues operations back to back with no idle gap, so every select follows another operation directly. Sum-of-differences and idle cycles are placed between writers and selects. Each select result is judged against a bench-side flag model that advances only on the opcodes that R2–R5 name.

// File: rtl/simd_addsub_pkg.sv
package simd_addsub_pkg;
  typedef enum logic [3:0] {
    OP_HADD  = 4'd0,
    OP_HSUB  = 4'd1,
    OP_BADD  = 4'd2,
    OP_BSUB  = 4'd3,
    OP_XADS  = 4'd4,
    OP_XSAD  = 4'd5,
    OP_SAD   = 4'd6,
    OP_SADA  = 4'd7,
    OP_BSEL  = 4'd8
  } simd_op_e;

  localparam int NUM_BYTES = 4;
endpackage

// File: rtl/simd_lane_addsub.sv
module simd_lane_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         ge
);
  logic [W:0] ext;
  logic [W-1:0] b_eff;

  always_comb begin
    b_eff = sub ? ~b : b;
    ext   = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
  end

  assign sum = ext[W-1:0];
  assign ge  = ext[W];
endmodule

// File: rtl/simd_sad_tree.sv
module simd_sad_tree #(
  parameter int W = 8,
  parameter int N = 4
) (
  input  logic [N*W-1:0] a,
  input  logic [N*W-1:0] b,
  input  logic [N*W-1:0] acc,
  input  logic           use_acc,
  output logic [N*W-1:0] total
);
  localparam int DW = N * W;

  logic [W-1:0] diff [N];

  for (genvar i = 0; i < N; i++) begin : g_absdiff
    logic [W-1:0] ai, bi;
    assign ai = a[i*W +: W];
    assign bi = b[i*W +: W];
    assign diff[i] = (ai >= bi) ? (ai - bi) : (bi - ai);
  end

  always_comb begin
    total = use_acc ? acc : '0;
    for (int i = 0; i < N; i++) begin
      total = total + {{(DW-W){1'b0}}, diff[i]};
    end
  end
endmodule

// File: rtl/simd_ge_reg.sv
module simd_ge_reg #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [N-1:0] ge_in,
  output logic [N-1:0] ge_q
);
  logic [N-1:0] ge_d;

  always_comb begin
    ge_d = ge_q;
    if (load) begin
      ge_d = ge_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ge_q <= '0;
    end else begin
      ge_q <= ge_d;
    end
  end
endmodule

// File: rtl/simd_addsub_unit.sv
module simd_addsub_unit
  import simd_addsub_pkg::*;
#(
  parameter int LANE_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      op_valid,
  input  logic [3:0]                op,
  input  logic [NUM_BYTES*LANE_W-1:0] opa,
  input  logic [NUM_BYTES*LANE_W-1:0] opb,
  input  logic [NUM_BYTES*LANE_W-1:0] acc,
  output logic [NUM_BYTES*LANE_W-1:0] result,
  output logic [NUM_BYTES-1:0]      ge_flags
);
  localparam int DW = NUM_BYTES * LANE_W;
  localparam int HW = 2 * LANE_W;

  simd_op_e sel_op;
  assign sel_op = simd_op_e'(op);

  logic is_half, is_byte, xchg;
  assign xchg    = (sel_op == OP_XADS) || (sel_op == OP_XSAD);
  assign is_half = (sel_op == OP_HADD) || (sel_op == OP_HSUB) || xchg;
  assign is_byte = (sel_op == OP_BADD) || (sel_op == OP_BSUB);

  // byte lanes
  logic [DW-1:0]        byte_res;
  logic [NUM_BYTES-1:0] byte_ge;
  for (genvar i = 0; i < NUM_BYTES; i++) begin : g_byte
    simd_lane_addsub #(.W(LANE_W)) u_lane (
      .a   (opa[i*LANE_W +: LANE_W]),
      .b   (opb[i*LANE_W +: LANE_W]),
      .sub (sel_op == OP_BSUB),
      .sum (byte_res[i*LANE_W +: LANE_W]),
      .ge  (byte_ge[i])
    );
  end

  // halfword lanes, cross-paired in the exchange forms
  logic [HW-1:0] hi_b, lo_b, hi_sum, lo_sum;
  logic          hi_sub, lo_sub, hi_ge, lo_ge;
  assign hi_b   = xchg ? opb[HW-1:0]  : opb[DW-1:HW];
  assign lo_b   = xchg ? opb[DW-1:HW] : opb[HW-1:0];
  assign hi_sub = (sel_op == OP_HSUB) || (sel_op == OP_XSAD);
  assign lo_sub = (sel_op == OP_HSUB) || (sel_op == OP_XADS);

  simd_lane_addsub #(.W(HW)) u_half_hi (
    .a(opa[DW-1:HW]), .b(hi_b), .sub(hi_sub), .sum(hi_sum), .ge(hi_ge)
  );
  simd_lane_addsub #(.W(HW)) u_half_lo (
    .a(opa[HW-1:0]), .b(lo_b), .sub(lo_sub), .sum(lo_sum), .ge(lo_ge)
  );

  // absolute-difference sum
  logic [DW-1:0] sad_res;
  simd_sad_tree #(.W(LANE_W), .N(NUM_BYTES)) u_sad (
    .a(opa), .b(opb), .acc(acc), .use_acc(sel_op == OP_SADA), .total(sad_res)
  );

  // flag-steered byte select
  logic [DW-1:0] sel_res;
  for (genvar i = 0; i < NUM_BYTES; i++) begin : g_sel
    assign sel_res[i*LANE_W +: LANE_W] =
      ge_flags[i] ? opa[i*LANE_W +: LANE_W] : opb[i*LANE_W +: LANE_W];
  end

  // flag register
  logic                 ge_load;
  logic [NUM_BYTES-1:0] ge_new;
  assign ge_load = op_valid && (is_half || is_byte);
  assign ge_new  = is_half ? {hi_ge, hi_ge, lo_ge, lo_ge} : byte_ge;

  simd_ge_reg #(.N(NUM_BYTES)) u_ge (
    .clk(clk), .rst_n(rst_n), .load(ge_load), .ge_in(ge_new), .ge_q(ge_flags)
  );

  always_comb begin
    unique case (sel_op)
      OP_HADD, OP_HSUB, OP_XADS, OP_XSAD: result = {hi_sum, lo_sum};
      OP_BADD, OP_BSUB:                   result = byte_res;
      OP_SAD, OP_SADA:                    result = sad_res;
      OP_BSEL:                            result = sel_res;
      default:                            result = '0;
    endcase
  end
endmodule

// File: rtl/simd_addsub_checker.sv
module simd_addsub_checker
  import simd_addsub_pkg::*;
#(
  parameter int LANE_W = 8
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        op_valid,
  input logic [3:0]                  op,
  input logic [NUM_BYTES*LANE_W-1:0] opa,
  input logic [NUM_BYTES*LANE_W-1:0] opb,
  input logic [NUM_BYTES*LANE_W-1:0] result,
  input logic [NUM_BYTES-1:0]        ge_flags
);
  localparam int DW = NUM_BYTES * LANE_W;

  logic writes_ge;
  assign writes_ge = op_valid && (op <= 4'd5);

  assert_ge_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (ge_flags == '0));

  assert_ge_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !writes_ge |=> $stable(ge_flags));

  assert_half_pair_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op == 4'd0 || op == 4'd1 || op == 4'd4 || op == 4'd5)) |=>
      (ge_flags[3] == ge_flags[2]) && (ge_flags[1] == ge_flags[0]));

  assert_byte0_add_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 4'd2) |-> (result[LANE_W-1:0] == LANE_W'(opa[LANE_W-1:0] + opb[LANE_W-1:0])));

  assert_sel_top_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 4'd8) |-> (result[DW-1 -: LANE_W] ==
      (ge_flags[NUM_BYTES-1] ? opa[DW-1 -: LANE_W] : opb[DW-1 -: LANE_W])));

  assert_undef_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (op > 4'd8) |-> (result == '0));
endmodule

bind simd_addsub_unit simd_addsub_checker #(.LANE_W(LANE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op(op),
  .opa(opa), .opb(opb), .result(result), .ge_flags(ge_flags)
);

// File: tb/simd_addsub_unit_tb.sv
module simd_addsub_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [3:0]  op = 4'd0;
  logic [31:0] opa = '0, opb = '0, acc = '0;
  logic [31:0] result;
  logic [3:0]  ge_flags;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [3:0] model_ge = 4'd0;

  always #5 clk = ~clk;

  simd_addsub_unit u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op(op),
    .opa(opa), .opb(opb), .acc(acc), .result(result), .ge_flags(ge_flags)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s op=%0d a=%h b=%h actual=%h expected=%h", req, op, opa, opb, act, exp);
    end
  endtask

  function automatic logic [16:0] hop(input logic [15:0] x, input logic [15:0] y, input bit s);
    int t;
    t = s ? (int'(x) - int'(y)) : (int'(x) + int'(y));
    return {(s ? (t >= 0) : (t >= 65536)), t[15:0]};
  endfunction

  function automatic logic [8:0] bop(input logic [7:0] x, input logic [7:0] y, input bit s);
    int t;
    t = s ? (int'(x) - int'(y)) : (int'(x) + int'(y));
    return {(s ? (t >= 0) : (t >= 256)), t[7:0]};
  endfunction

  // returns {next flags, result}
  function automatic logic [35:0] ref_op(input logic [3:0] o, input logic [31:0] a,
                                         input logic [31:0] b, input logic [31:0] c,
                                         input logic [3:0] g);
    logic [16:0] h1, h0;
    logic [8:0]  q [4];
    logic [31:0] r;
    logic [3:0]  gn;
    longint s;
    gn = g; r = '0;
    case (o)
      4'd0, 4'd1: begin
        h1 = hop(a[31:16], b[31:16], o == 4'd1);
        h0 = hop(a[15:0],  b[15:0],  o == 4'd1);
        r = {h1[15:0], h0[15:0]}; gn = {h1[16], h1[16], h0[16], h0[16]};
      end
      4'd4, 4'd5: begin
        h1 = hop(a[31:16], b[15:0],  o == 4'd5);
        h0 = hop(a[15:0],  b[31:16], o == 4'd4);
        r = {h1[15:0], h0[15:0]}; gn = {h1[16], h1[16], h0[16], h0[16]};
      end
      4'd2, 4'd3: begin
        for (int i = 0; i < 4; i++) begin
          q[i] = bop(a[i*8 +: 8], b[i*8 +: 8], o == 4'd3);
          r[i*8 +: 8] = q[i][7:0];
          gn[i] = q[i][8];
        end
      end
      4'd6, 4'd7: begin
        s = (o == 4'd7) ? longint'(c) : 0;
        for (int i = 0; i < 4; i++) begin
          int d;
          d = int'(a[i*8 +: 8]) - int'(b[i*8 +: 8]);
          s += (d < 0) ? -d : d;
        end
        r = s[31:0];
      end
      4'd8: begin
        for (int i = 0; i < 4; i++) r[i*8 +: 8] = g[i] ? a[i*8 +: 8] : b[i*8 +: 8];
      end
      default: r = '0;
    endcase
    return {gn, r};
  endfunction

  function automatic string req_of(input logic [3:0] o);
    case (o)
      4'd0, 4'd1: return "R2";
      4'd2, 4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7: return "R7";
      4'd8: return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic issue(input logic [3:0] o, input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] c, input bit v);
    logic [35:0] e;
    @(negedge clk);
    op = o; opa = a; opb = b; acc = c; op_valid = v;
    e = ref_op(o, a, b, c, model_ge);
    #1;
    check(req_of(o), result, e[31:0]);
    @(posedge clk);
    #1;
    if (v) model_ge = e[35:32];
    check((v && o <= 4'd5) ? req_of(o) : "R9", {28'd0, ge_flags}, {28'd0, model_ge});
  endtask

  function automatic logic [7:0] edgev(input int k);
    case (k & 3)
      0: return 8'h00;
      1: return 8'h7F;
      2: return 8'h80;
      default: return 8'hFF;
    endcase
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1", {28'd0, ge_flags}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1", {28'd0, ge_flags}, 32'd0);

    // boundary patterns, every opcode back to back
    for (int x = 0; x < 4; x++) begin
      for (int y = 0; y < 4; y++) begin
        for (int o = 0; o < 16; o++) begin
          issue(4'(o), {4{edgev(x)}}, {4{edgev(y)}}, 32'hFFFF_FFF0, 1'b1);
        end
      end
    end
    // mixed boundary bytes
    for (int n = 0; n < 256; n++) begin
      logic [31:0] a, b;
      for (int i = 0; i < 4; i++) begin
        a[i*8 +: 8] = edgev((n >> i) & 3);
        b[i*8 +: 8] = edgev((n >> (i + 2)) & 3);
      end
      for (int o = 0; o < 9; o++) issue(4'(o), a, b, $urandom, 1'b1);
    end
    // exhaustive sweep of the low byte lane against boundary values
    for (int v = 0; v < 256; v++) begin
      for (int k = 0; k < 4; k++) begin
        issue(4'd2, {24'h80FF7F, 8'(v)}, {24'h7F0180, edgev(k)}, 32'd0, 1'b1);
        issue(4'd3, {24'h00FF80, 8'(v)}, {24'h017F80, edgev(k)}, 32'd0, 1'b1);
        issue(4'd8, $urandom, $urandom, 32'd0, 1'b1);
      end
    end
    // writers followed by non-writers and idle cycles before a select
    for (int n = 0; n < 400; n++) begin
      issue(4'($urandom_range(0, 5)), $urandom, $urandom, $urandom, 1'b1);
      issue(4'($urandom_range(6, 7)), $urandom, $urandom, $urandom, 1'b1);
      issue(4'($urandom_range(0, 5)), $urandom, $urandom, $urandom, 1'b0);
      issue(4'($urandom_range(9, 15)), $urandom, $urandom, $urandom, 1'b1);
      issue(4'd8, $urandom, $urandom, $urandom, 1'b1);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule